// File: doc/BRIEF.md
# Branch Steering and Wrong-Path Squash Controller

This controller owns the fetch program counter of a five-stage in-order pipeline and decides, every cycle, which address is fetched next. When the word being fetched is pre-decoded as a conditional branch, a history table indexed by low PC bits gives a guess. A guess of taken steers fetch to the branch target. A guess of not taken, or no branch at all, lets fetch continue to the next sequential word. With no history table the fetch path always assumes not taken.

Later in the pipe the branch reaches its resolution stage. That stage is execute by default, or decode when the comparator is moved early. There the controller compares two register operands and checks the outcome against the guess that travelled with the branch. On a wrong guess it sends fetch to the correct path in the same cycle. It also raises squash signals that turn the younger wrong-path instructions into no-ops, which then drain through the remaining stages. Resolution in execute squashes the fetch and decode slots, a two-cycle loss. Resolution in decode squashes only the fetch slot, a one-cycle loss. Every resolved branch trains the history entry of its own PC.

Top module: `branch_steer`

## Requirements
- R1: While reset is asserted and after its release, `fetch_pc` equals `RESET_PC`, and `redirect`, `flush_if` and `flush_id` are low while no branch is resolving.
- R2: When there is no redirect and `fetch_pred` is low, `fetch_pc` advances by 4 on the next clock.
- R3: When there is no redirect and `fetch_pred` is high, the next `fetch_pc` is `fetch_pc + 4 + (sign-extended fe_off << 2)`. `fetch_pred` is only ever high while `fe_is_br` is high.
- R4: The branch condition is selected by `rs_kind`: 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, applied as (`rs_opa` op `rs_opb`).
- R5: When `rs_valid` is high and the resolved outcome differs from `rs_pred`, `redirect` and `flush_if` rise combinationally in that cycle. The next `fetch_pc` is then `rs_pc + 4 + (sign-extended rs_off << 2)` if taken, or `rs_pc + 4` if not taken.
- R6: With `RESOLVE_IN_ID = 0`, a misprediction also raises `flush_id`, so two younger slots are squashed.
- R7: With `RESOLVE_IN_ID = 1`, `flush_id` stays low and a misprediction squashes only the fetch slot.
- R8: A resolving branch whose outcome matches `rs_pred` causes no redirect and no squash. Nothing happens while `rs_valid` is low.
- R9: With `PRED_MODE = 1`, the guess for a PC is the last resolved outcome recorded at its table entry. The initial guess is not taken.
- R10: With `PRED_MODE = 2`, each entry is a saturating 2-bit counter that resets to 01. It counts up on taken and down on not taken, saturates at 00 and 11, and guesses taken when its high bit is 1. From a strong state, two consecutive opposite outcomes are needed to flip the guess.
- R11: The table entry is selected by PC bits [IDX_W+1:2] for both lookup and training. Training happens only when `rs_valid` is high. A lookup in the same cycle as training at the same entry returns the value held before training.
- R12: With `PRED_MODE = 0`, `fetch_pred` is always low, so fetch always assumes not taken.
- R13: When a redirect and a taken guess for the fetched word fall in the same cycle, the redirect decides the next `fetch_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_is_br | input | 1 | Fetched word pre-decodes as a conditional branch |
| fe_off | input | 16 | Word offset field of the fetched branch |
| fetch_pc | output | PC_W | Address being fetched this cycle |
| fetch_pred | output | 1 | Guess of taken for the fetched branch, to be carried down the pipe |
| rs_valid | input | 1 | A branch occupies the resolution stage |
| rs_pc | input | PC_W | PC of the resolving branch |
| rs_opa | input | DATA_W | First compare operand |
| rs_opb | input | DATA_W | Second compare operand |
| rs_kind | input | 2 | Condition code (see R4) |
| rs_off | input | 16 | Word offset field of the resolving branch |
| rs_pred | input | 1 | Guess recorded when the resolving branch was fetched |
| redirect | output | 1 | Fetch is being steered to the corrected path |
| flush_if | output | 1 | Turn the fetch-slot instruction into a no-op |
| flush_id | output | 1 | Turn the decode-slot instruction into a no-op |

## Verification
Two things can happen in one cycle: a wrong guess resolving, and a newly fetched branch being guessed taken. Each then wants a different next address. The bench provokes this by raising `fe_is_br` after training an entry to taken, in the same cycle as it resolves a branch against its recorded guess. It expects the corrected path to win and the squash to rise. Training and lookup of the same table entry are also driven together, and the guess is expected to reflect the state held before training. Three instances run in parallel: execute resolution with 2-bit history, decode resolution with 1-bit history, and the static policy. A reference model of the table for each instance supplies the scoreboard with the expected address sequence.

// File: rtl/branch_steer_pkg.sv
package branch_steer_pkg;

    localparam int BR_OFF_W = 16;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_NE = 2'd1,
        CMP_LT = 2'd2,
        CMP_GE = 2'd3
    } cmp_kind_e;

    localparam int PRED_STATIC = 0;
    localparam int PRED_ONEBIT = 1;
    localparam int PRED_TWOBIT = 2;

endpackage

// File: rtl/bs_cond_eval.sv
module bs_cond_eval
    import branch_steer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        kind,
    output logic              taken
);

    logic eq_w;
    logic lt_w;

    assign eq_w = (opa == opb);
    assign lt_w = ($signed(opa) < $signed(opb));

    always_comb begin
        case (cmp_kind_e'(kind))
            CMP_EQ:  taken = eq_w;
            CMP_NE:  taken = !eq_w;
            CMP_LT:  taken = lt_w;
            default: taken = !lt_w;
        endcase
    end

endmodule

// File: rtl/bs_hist_table.sv
module bs_hist_table
    import branch_steer_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int MODE  = PRED_TWOBIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int ENTRIES = 1 << IDX_W;

    generate
        if (MODE == PRED_STATIC) begin : g_static
            assign rd_taken = 1'b0;
        end else begin : g_dyn
            localparam int CW = (MODE == PRED_TWOBIT) ? 2 : 1;
            localparam logic [CW-1:0] INIT = (MODE == PRED_TWOBIT) ? CW'(1) : CW'(0);

            logic [CW-1:0] cnt_d [ENTRIES];
            logic [CW-1:0] cnt_q [ENTRIES];

            if (MODE == PRED_TWOBIT) begin : g_two
                always_comb begin
                    cnt_d = cnt_q;
                    if (wr_en) begin
                        if (wr_taken && cnt_q[wr_idx] != 2'b11)
                            cnt_d[wr_idx] = cnt_q[wr_idx] + 2'b01;
                        else if (!wr_taken && cnt_q[wr_idx] != 2'b00)
                            cnt_d[wr_idx] = cnt_q[wr_idx] - 2'b01;
                    end
                end
            end else begin : g_one
                always_comb begin
                    cnt_d = cnt_q;
                    if (wr_en)
                        cnt_d[wr_idx] = CW'(wr_taken);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int e = 0; e < ENTRIES; e++)
                        cnt_q[e] <= INIT;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign rd_taken = cnt_q[rd_idx][CW-1];
        end
    endgenerate

endmodule

// File: rtl/branch_steer.sv
module branch_steer
    import branch_steer_pkg::*;
#(
    parameter int              PC_W          = 32,
    parameter int              DATA_W        = 32,
    parameter int              IDX_W         = 4,
    parameter int              PRED_MODE     = PRED_TWOBIT,
    parameter int              RESOLVE_IN_ID = 0,
    parameter logic [PC_W-1:0] RESET_PC      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fe_is_br,
    input  logic [15:0]       fe_off,
    output logic [PC_W-1:0]   fetch_pc,
    output logic              fetch_pred,
    input  logic              rs_valid,
    input  logic [PC_W-1:0]   rs_pc,
    input  logic [DATA_W-1:0] rs_opa,
    input  logic [DATA_W-1:0] rs_opb,
    input  logic [1:0]        rs_kind,
    input  logic [15:0]       rs_off,
    input  logic              rs_pred,
    output logic              redirect,
    output logic              flush_if,
    output logic              flush_id
);

    localparam logic [PC_W-1:0] STEP = PC_W'(4);
    localparam int              PAD  = PC_W - BR_OFF_W - 2;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } steer_t;

    steer_t st_d, st_q;

    logic             res_taken;
    logic             hist_taken;
    logic             mispred;
    logic [PC_W-1:0]  res_target;
    logic [PC_W-1:0]  fe_target;
    logic [PC_W-1:0]  fall_pc;

    function automatic logic [PC_W-1:0] jump_to(input logic [PC_W-1:0] base,
                                                input logic [BR_OFF_W-1:0] off);
        return base + STEP + {{PAD{off[BR_OFF_W-1]}}, off, 2'b00};
    endfunction

    bs_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .opa   (rs_opa),
        .opb   (rs_opb),
        .kind  (rs_kind),
        .taken (res_taken)
    );

    bs_hist_table #(.IDX_W(IDX_W), .MODE(PRED_MODE)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (st_q.pc[IDX_W+1:2]),
        .rd_taken (hist_taken),
        .wr_en    (rs_valid),
        .wr_idx   (rs_pc[IDX_W+1:2]),
        .wr_taken (res_taken)
    );

    always_comb begin
        res_target = jump_to(rs_pc, rs_off);
        fe_target  = jump_to(st_q.pc, fe_off);
        fall_pc    = rs_pc + STEP;
        mispred    = rs_valid && (res_taken != rs_pred);
        fetch_pred = fe_is_br && hist_taken;

        st_d = st_q;
        if (mispred)
            st_d.pc = res_taken ? res_target : fall_pc;
        else if (fetch_pred)
            st_d.pc = fe_target;
        else
            st_d.pc = st_q.pc + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.pc <= RESET_PC;
        else
            st_q <= st_d;
    end

    generate
        if (RESOLVE_IN_ID != 0) begin : g_early
            assign flush_id = 1'b0;
        end else begin : g_late
            assign flush_id = mispred;
        end
    endgenerate

    assign fetch_pc = st_q.pc;
    assign redirect = mispred;
    assign flush_if = mispred;

endmodule

// File: rtl/branch_steer_chk.sv
module branch_steer_chk #(
    parameter int PC_W          = 32,
    parameter int RESOLVE_IN_ID = 0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fe_is_br,
    input logic [15:0]     fe_off,
    input logic [PC_W-1:0] fetch_pc,
    input logic            fetch_pred,
    input logic            rs_valid,
    input logic [PC_W-1:0] rs_pc,
    input logic [15:0]     rs_off,
    input logic            redirect,
    input logic            flush_if,
    input logic            flush_id
);

    localparam logic [PC_W-1:0] FOUR = PC_W'(4);

    function automatic logic [PC_W-1:0] word_off(input logic [15:0] o);
        return {{(PC_W-18){o[15]}}, o, 2'b00};
    endfunction

    // R6
    id_squash_implies_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_id |-> flush_if);

    // R7
    early_resolve_no_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RESOLVE_IN_ID != 0) |-> !flush_id);

    // R5
    squash_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_if |-> (rs_valid && redirect));

    // R2
    sequential_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !fetch_pred) |=> fetch_pc == $past(fetch_pc) + FOUR);

    // R3
    guessed_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && fetch_pred) |=>
            fetch_pc == $past(fetch_pc) + FOUR + word_off($past(fe_off)));

    // R3
    guess_only_on_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pred |-> fe_is_br);

    // R5
    redirect_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (fetch_pc == $past(rs_pc) + FOUR) ||
                     (fetch_pc == $past(rs_pc) + FOUR + word_off($past(rs_off))));

endmodule

bind branch_steer branch_steer_chk #(.PC_W(PC_W), .RESOLVE_IN_ID(RESOLVE_IN_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fe_is_br   (fe_is_br),
    .fe_off     (fe_off),
    .fetch_pc   (fetch_pc),
    .fetch_pred (fetch_pred),
    .rs_valid   (rs_valid),
    .rs_pc      (rs_pc),
    .rs_off     (rs_off),
    .redirect   (redirect),
    .flush_if   (flush_if),
    .flush_id   (flush_id)
);

// File: tb/test_branch_steer.sv
module test_branch_steer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fe_is_br = 1'b0;
    logic [15:0] fe_off = '0;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic [31:0] rs_opa = '0;
    logic [31:0] rs_opb = '0;
    logic [1:0]  rs_kind = '0;
    logic [15:0] rs_off = '0;
    logic        rs_pred [3];

    logic [31:0] fpc [3];
    logic        fpr [3];
    logic        rdr [3];
    logic        fif [3];
    logic        fid [3];

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // instance 0: execute resolution, 2-bit; 1: decode resolution, 1-bit; 2: static
    int          mmode [3] = '{2, 1, 0};
    bit          mearly [3] = '{1'b0, 1'b1, 1'b0};
    logic [1:0]  tab [3][16];
    logic [31:0] mpc [3];

    int          qi [$];
    logic [31:0] qp [$];
    string       qt [$];

    always #2.5 clk = ~clk;

    initial for (int i = 0; i < 3; i++) rs_pred[i] = 1'b0;

    branch_steer #(.PRED_MODE(2), .RESOLVE_IN_ID(0)) i_branch_steer (
        .clk(clk), .rst_n(rst_n), .fe_is_br(fe_is_br), .fe_off(fe_off),
        .fetch_pc(fpc[0]), .fetch_pred(fpr[0]), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_opa(rs_opa), .rs_opb(rs_opb), .rs_kind(rs_kind), .rs_off(rs_off),
        .rs_pred(rs_pred[0]), .redirect(rdr[0]), .flush_if(fif[0]), .flush_id(fid[0]));

    branch_steer #(.PRED_MODE(1), .RESOLVE_IN_ID(1)) i_branch_steer_id (
        .clk(clk), .rst_n(rst_n), .fe_is_br(fe_is_br), .fe_off(fe_off),
        .fetch_pc(fpc[1]), .fetch_pred(fpr[1]), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_opa(rs_opa), .rs_opb(rs_opb), .rs_kind(rs_kind), .rs_off(rs_off),
        .rs_pred(rs_pred[1]), .redirect(rdr[1]), .flush_if(fif[1]), .flush_id(fid[1]));

    branch_steer #(.PRED_MODE(0), .RESOLVE_IN_ID(0)) i_branch_steer_st (
        .clk(clk), .rst_n(rst_n), .fe_is_br(fe_is_br), .fe_off(fe_off),
        .fetch_pc(fpc[2]), .fetch_pred(fpr[2]), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_opa(rs_opa), .rs_opb(rs_opb), .rs_kind(rs_kind), .rs_off(rs_off),
        .rs_pred(rs_pred[2]), .redirect(rdr[2]), .flush_if(fif[2]), .flush_id(fid[2]));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic mguess(input int i, input logic [31:0] pc);
        if (mmode[i] == 2) return tab[i][pc[5:2]][1];
        if (mmode[i] == 1) return tab[i][pc[5:2]][0];
        return 1'b0;
    endfunction

    function automatic logic [31:0] mjump(input logic [31:0] pc, input logic [15:0] o);
        return pc + 32'd4 + {{14{o[15]}}, o, 2'b00};
    endfunction

    // R4 reference: 0 eq, 1 ne, 2 signed lt, 3 signed ge
    function automatic logic mcond(input logic [31:0] a, input logic [31:0] b,
                                   input logic [1:0] k);
        case (k)
            2'd0:    return a == b;
            2'd1:    return a != b;
            2'd2:    return $signed(a) < $signed(b);
            default: return $signed(a) >= $signed(b);
        endcase
    endfunction

    // Scoreboard monitor: expected fetch addresses, compared after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (qi.size() > 0) begin
                int          i;
                logic [31:0] p;
                string       t;
                i = qi.pop_front();
                p = qp.pop_front();
                t = qt.pop_front();
                chk(fpc[i] == p, t, fpc[i], p);
            end
        end
    end

    task automatic step(input logic fb, input logic [15:0] fo, input logic rv,
                        input logic [31:0] rp, input logic [31:0] ra,
                        input logic [31:0] rb, input logic [1:0] rk,
                        input logic [15:0] ro);
        logic        pr [3];
        logic        tk;
        logic        mis;
        logic        fg;
        logic [31:0] nx;
        string       t;
        for (int i = 0; i < 3; i++) pr[i] = rv && mguess(i, rp);
        @(negedge clk);
        fe_is_br = fb; fe_off = fo; rs_valid = rv; rs_pc = rp;
        rs_opa = ra; rs_opb = rb; rs_kind = rk; rs_off = ro;
        for (int i = 0; i < 3; i++) rs_pred[i] = pr[i];
        #1;
        tk = mcond(ra, rb, rk);
        for (int i = 0; i < 3; i++) begin
            mis = rv && (tk != pr[i]);
            fg  = fb && mguess(i, mpc[i]);
            // R4 R5 R8: squash and redirect follow the outcome check
            chk(fif[i] == mis, mis ? "R5 R4 flush_if" : "R8 flush_if", 32'(fif[i]), 32'(mis));
            chk(rdr[i] == mis, mis ? "R5 redirect" : "R8 redirect", 32'(rdr[i]), 32'(mis));
            // R6 two slots when resolving in execute, R7 one slot when in decode
            chk(fid[i] == (mis && !mearly[i]), mearly[i] ? "R7 flush_id" : "R6 flush_id",
                32'(fid[i]), 32'(mis && !mearly[i]));
            t = (mmode[i] == 2) ? "R10 R11 fetch_pred" :
                (mmode[i] == 1) ? "R9 R11 fetch_pred" : "R12 fetch_pred";
            chk(fpr[i] == fg, t, 32'(fpr[i]), 32'(fg));
            if (mis) begin
                nx = tk ? mjump(rp, ro) : rp + 32'd4;
                t  = fg ? "R13 next_pc" : "R5 next_pc";
            end else if (fg) begin
                nx = mjump(mpc[i], fo);
                t  = "R3 next_pc";
            end else begin
                nx = mpc[i] + 32'd4;
                t  = "R2 next_pc";
            end
            qi.push_back(i); qp.push_back(nx); qt.push_back(t);
            mpc[i] = nx;
            if (rv) begin
                if (mmode[i] == 2) begin
                    if (tk && tab[i][rp[5:2]] != 2'b11) tab[i][rp[5:2]] += 2'b01;
                    else if (!tk && tab[i][rp[5:2]] != 2'b00) tab[i][rp[5:2]] -= 2'b01;
                end else begin
                    tab[i][rp[5:2]] = {1'b0, tk};
                end
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            mpc[i] = 32'd0;
            for (int e = 0; e < 16; e++) tab[i][e] = (mmode[i] == 2) ? 2'b01 : 2'b00;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            // R1 reset state
            chk(fpc[i] == 32'd0, "R1 reset pc", fpc[i], 32'd0);
            chk(!fif[i] && !fid[i] && !rdr[i], "R1 reset flush", 32'(fif[i]), 32'd0);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 plain sequential fetch
        repeat (4) step(1'b0, 16'd0, 1'b0, 32'd0, 32'd0, 32'd0, 2'd0, 16'd0);
        // R11 first guess at a fresh entry is not taken
        step(1'b1, 16'd8, 1'b0, 32'd0, 32'd0, 32'd0, 2'd0, 16'd0);
        // R5 R6 R7 taken branch at 0x40, guessed not taken everywhere
        step(1'b0, 16'd0, 1'b1, 32'h40, 32'd5, 32'd5, 2'd0, 16'd16);
        // R9 R10 train the same entry taken again, then not taken once
        step(1'b0, 16'd0, 1'b1, 32'h40, 32'd5, 32'd5, 2'd0, 16'd16);
        step(1'b0, 16'd0, 1'b1, 32'h40, 32'd5, 32'd5, 2'd0, 16'd16);
        step(1'b0, 16'd0, 1'b1, 32'h40, 32'd5, 32'd6, 2'd0, 16'd16);
        // R10 2-bit still guesses taken, R9 1-bit now guesses not taken
        step(1'b0, 16'd0, 1'b1, 32'h40, 32'd5, 32'd6, 2'd0, 16'd16);
        step(1'b0, 16'd0, 1'b1, 32'h40, 32'd5, 32'd6, 2'd0, 16'd16);
        // R4 kinds with signed operands and a backward offset
        step(1'b0, 16'd0, 1'b1, 32'h80, 32'd7, 32'd3, 2'd1, 16'hFFF0);
        step(1'b0, 16'd0, 1'b1, 32'h84, -32'sd3, 32'd2, 2'd2, 16'h0004);
        step(1'b0, 16'd0, 1'b1, 32'h88, -32'sd3, 32'd2, 2'd3, 16'h0004);
        step(1'b0, 16'd0, 1'b1, 32'h8C, 32'd2, -32'sd3, 2'd3, 16'hFFFC);
        // R13 train every entry to taken, then collide a guessed jump with a redirect
        for (int e = 0; e < 16; e++)
            repeat (2) step(1'b0, 16'd0, 1'b1, 32'(e * 4), 32'd1, 32'd1, 2'd0, 16'd3);
        step(1'b1, 16'd20, 1'b1, 32'h100, 32'd1, 32'd2, 2'd2, 16'd9);
        step(1'b1, 16'd20, 1'b1, 32'h104, 32'd1, 32'd1, 2'd1, 16'd9);
        // mixed traffic
        for (int n = 0; n < 400; n++)
            step(($urandom % 3) == 0, 16'($urandom_range(0, 63)) - 16'd32,
                 ($urandom % 2) == 0, 32'($urandom_range(0, 255)) & 32'hFFFF_FFFC,
                 32'($urandom_range(0, 6)) - 32'd3, 32'($urandom_range(0, 6)) - 32'd3,
                 2'($urandom % 4), 16'($urandom_range(0, 63)) - 16'd32);
        step(1'b0, 16'd0, 1'b0, 32'd0, 32'd0, 32'd0, 2'd0, 16'd0);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

endmodule